// File: doc/BRIEF.md
# Shared Packet Bus Arbiter Node

This block arbitrates one shared packet bus among several boards. Exactly one board is the controller. It owns the bus by default, drives a busy line, and has a dedicated request input and grant output for every peripheral board. Every other board is a peripheral. It raises its own request line while it has packets queued, and it drives the bus only once it has been granted.

The same module is instantiated on every board. A strap input, sampled as a static setting while reset is held, selects the controller or peripheral role. Packets come from a local source that presents `txValid` and `txData`. The block pops one packet per cycle while it is allowed to drive. It outputs the bus data and an output enable, and the physical pad and link logic sit outside the block.

In the controller role, pending peripheral requests are served in rotating order. The controller sends its own packets only when the bus is idle and no peripheral is asking for it. A granted peripheral keeps the bus for as long as it keeps its request high. After it releases the bus there is one turnaround cycle before the bus returns to idle.

Top module: `sharedBusArbiter`

## Requirements
- R1: While `rstN` is low, `slvGnt`, `busyOut`, `reqOut`, `busOe`, `txPop` and `busDout` are all zero.
- R2: In the controller role, when `busyOut` is low and any bit of `slvReq` is high, the following cycle shows exactly one grant bit high together with `busyOut` high.
- R3: In the peripheral role, `reqOut` rises in the cycle after the block is idle with `txValid` high. The block drives the bus (`busOe`) only in cycles after one in which it sampled `grantIn` high, and only while `grantIn` is still high.
- R4: A grant stays high as long as that peripheral's request stays high. It is cleared in the cycle after the request is seen low. `busyOut` stays high for that single turnaround cycle, with nobody driving, and then falls.
- R5: Grant index k means `slvGnt` bit k. With several requests pending, the next grant goes to the first requesting index above the previously granted one, wrapping from NSLV-1 to 0. After reset the previous index counts as NSLV-1, so index 0 has top priority.
- R6: The controller starts sending its own packets only from idle (busy low) with no request pending. `busyOut` is high while it sends. It stops sending at the first cycle that `txValid` is low, returns to idle the cycle after that, and only then grants waiting peripherals.
- R7: `busOe` is never high in a cycle in which any `slvGnt` bit is high.
- R8: In the peripheral role, `slvGnt` and `busyOut` stay zero whatever `slvReq` does. In the controller role, `reqOut` stays zero.
- R9: `txPop` equals `busOe`. `busDout` equals `txData` while `busOe` is high and is zero otherwise, and one packet moves per driving cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| isMaster | input | 1 | Role strap: 1 selects controller, 0 selects peripheral |
| txValid | input | 1 | Local packet source has a packet |
| txData | input | DW | Packet at the head of the local source |
| txPop | output | 1 | Head packet consumed this cycle |
| slvReq | input | NSLV | Controller role: request line from each peripheral |
| slvGnt | output | NSLV | Controller role: grant line to each peripheral |
| busyOut | output | 1 | Controller role: bus busy line |
| reqOut | output | 1 | Peripheral role: this board's request line |
| grantIn | input | 1 | Peripheral role: this board's grant line |
| busDout | output | DW | Data presented to the shared bus |
| busOe | output | 1 | Output enable for the bus data |

## Verification
A corrupted controller state shows up within one cycle as a busy line that disagrees with the grant lines, or as a grant that outlives its request by more than one cycle. A wrong rotation pointer does not show until two or more requests overlap, and then it appears as the wrong grant order on the next arbitration. A peripheral that starts driving before its grant, or an enable that overlaps a grant, shows up in the very cycle it happens as two drivers on the bus. For that reason the controller's grant, busy and enable outputs are compared against an independent model on every clock.

// File: rtl/sbArbPkg.sv
package sbArbPkg;
  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_SEND  = 2'd1,
    M_GRANT = 2'd2,
    M_TURN  = 2'd3
  } mState_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_XFER = 2'd2
  } sState_t;

  typedef struct packed {
    logic sendSlot;
    logic ownerLocal;
  } busStrobe_t;
endpackage

// File: rtl/sbRrPicker.sv
module sbRrPicker #(
  parameter int NSLV  = 3,
  parameter int IDX_W = 2
) (
  input  logic [NSLV-1:0]  req,
  input  logic [IDX_W-1:0] lastIdx,
  output logic             anyReq,
  output logic [IDX_W-1:0] winIdx
);
  always_comb begin
    anyReq = |req;
    winIdx = '0;
    for (int off = NSLV; off >= 1; off--) begin
      int cand;
      cand = int'(lastIdx) + off;
      if (cand >= NSLV) cand = cand - NSLV;
      if (req[cand]) winIdx = IDX_W'(cand);
    end
  end
endmodule

// File: rtl/sbMasterCtl.sv
module sbMasterCtl import sbArbPkg::*; #(
  parameter int NSLV  = 3,
  parameter int IDX_W = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            txValid,
  input  logic [NSLV-1:0] slvReq,
  output logic [NSLV-1:0] slvGnt,
  output logic            busyOut,
  output busStrobe_t      stb
);
  mState_t          state;
  logic [IDX_W-1:0] owner;
  logic [IDX_W-1:0] lastIdx;
  logic             anyReq;
  logic [IDX_W-1:0] winIdx;

  sbRrPicker #(.NSLV(NSLV), .IDX_W(IDX_W)) uPick (
    .req    (slvReq),
    .lastIdx(lastIdx),
    .anyReq (anyReq),
    .winIdx (winIdx)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= M_IDLE;
      owner   <= '0;
      lastIdx <= IDX_W'(NSLV - 1);
    end else if (!enable) begin
      state <= M_IDLE;
    end else begin
      case (state)
        M_IDLE: begin
          if (anyReq) begin
            state   <= M_GRANT;
            owner   <= winIdx;
            lastIdx <= winIdx;
          end else if (txValid) begin
            state <= M_SEND;
          end
        end
        M_SEND:  if (!txValid) state <= M_IDLE;
        M_GRANT: if (!slvReq[owner]) state <= M_TURN;
        M_TURN:  state <= M_IDLE;
        default: state <= M_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NSLV; g++) begin : gGnt
    assign slvGnt[g] = (state == M_GRANT) && (owner == IDX_W'(g));
  end

  assign busyOut        = (state != M_IDLE);
  assign stb.sendSlot   = (state == M_SEND);
  assign stb.ownerLocal = (state == M_SEND) || (state == M_IDLE);

  AST_GNT_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (|(slvGnt & ~slvReq)) |=> (slvGnt == '0)); // R4
  AST_GNT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|slvGnt) |-> $past(!busyOut)); // R2
  AST_BUSY_TURN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(|slvGnt) |-> busyOut); // R4
endmodule

// File: rtl/sbSlaveCtl.sv
module sbSlaveCtl import sbArbPkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       txValid,
  input  logic       grantIn,
  output logic       reqOut,
  output busStrobe_t stb
);
  sState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
    end else if (!enable) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:  if (txValid) state <= S_WAIT;
        S_WAIT:  if (grantIn) state <= S_XFER;
        S_XFER:  if (!txValid) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign reqOut         = (state != S_IDLE);
  assign stb.sendSlot   = (state == S_XFER) && grantIn;
  assign stb.ownerLocal = (state == S_XFER);

  AST_SLV_WAIT_GNT: assert property (@(posedge clk) disable iff (!rstN)
    stb.sendSlot |-> $past(grantIn)); // R3
endmodule

// File: rtl/sbBusDatapath.sv
module sbBusDatapath import sbArbPkg::*; #(
  parameter int DW = 16
) (
  input  logic          txValid,
  input  logic [DW-1:0] txData,
  input  busStrobe_t    mStb,
  input  busStrobe_t    sStb,
  output logic [DW-1:0] busDout,
  output logic          busOe,
  output logic          txPop
);
  logic drive;

  assign drive   = txValid && ((mStb.sendSlot && mStb.ownerLocal) ||
                               (sStb.sendSlot && sStb.ownerLocal));
  assign busOe   = drive;
  assign txPop   = drive;
  assign busDout = drive ? txData : '0;
endmodule

// File: rtl/sharedBusArbiter.sv
module sharedBusArbiter import sbArbPkg::*; #(
  parameter int NSLV = 3,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            isMaster,
  input  logic            txValid,
  input  logic [DW-1:0]   txData,
  output logic            txPop,
  input  logic [NSLV-1:0] slvReq,
  output logic [NSLV-1:0] slvGnt,
  output logic            busyOut,
  output logic            reqOut,
  input  logic            grantIn,
  output logic [DW-1:0]   busDout,
  output logic            busOe
);
  localparam int IDX_W = (NSLV > 1) ? $clog2(NSLV) : 1;

  busStrobe_t mStb;
  busStrobe_t sStb;

  sbMasterCtl #(.NSLV(NSLV), .IDX_W(IDX_W)) uMaster (
    .clk    (clk),
    .rstN   (rstN),
    .enable (isMaster),
    .txValid(txValid),
    .slvReq (slvReq),
    .slvGnt (slvGnt),
    .busyOut(busyOut),
    .stb    (mStb)
  );

  sbSlaveCtl uSlave (
    .clk    (clk),
    .rstN   (rstN),
    .enable (!isMaster),
    .txValid(txValid),
    .grantIn(grantIn),
    .reqOut (reqOut),
    .stb    (sStb)
  );

  sbBusDatapath #(.DW(DW)) uData (
    .txValid(txValid),
    .txData (txData),
    .mStb   (mStb),
    .sStb   (sStb),
    .busDout(busDout),
    .busOe  (busOe),
    .txPop  (txPop)
  );

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> (slvGnt == '0)); // R7
  AST_ROLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    isMaster |-> !reqOut); // R8
endmodule

// File: tb/tb_sharedBusArbiter.sv
`timescale 1ns/1ps
module tb_sharedBusArbiter;
  localparam int NSLV = 3;
  localparam int DW   = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            isMaster = 1'b1;
  logic            txValid;
  logic [DW-1:0]   txData;
  logic            txPop;
  logic [NSLV-1:0] slvReq;
  logic [NSLV-1:0] slvGnt;
  logic            busyOut;
  logic            reqOut;
  logic            grantIn;
  logic [DW-1:0]   busDout;
  logic            busOe;

  always #2 clk = ~clk;

  sharedBusArbiter #(.NSLV(NSLV), .DW(DW)) dut (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .txValid(txValid),
    .txData(txData), .txPop(txPop), .slvReq(slvReq), .slvGnt(slvGnt),
    .busyOut(busyOut), .reqOut(reqOut), .grantIn(grantIn),
    .busDout(busDout), .busOe(busOe)
  );

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  // local packet source
  int srcCount = 0;
  logic [DW-1:0] srcSeq = 16'h0100;
  assign txValid = (srcCount > 0);
  assign txData  = srcSeq;
  always @(posedge clk) if (txPop) begin
    srcCount <= srcCount - 1;
    srcSeq   <= srcSeq + 1'b1;
  end

  // emulated peripherals (controller phase) and request noise (peripheral phase)
  int holdLen [NSLV];
  logic [NSLV-1:0] slvReqR = '0;
  logic [NSLV-1:0] noiseReq = '0;
  assign slvReq = isMaster ? slvReqR : noiseReq;
  initial for (int i = 0; i < NSLV; i++) holdLen[i] = 0;

  always @(posedge clk) begin
    if (!rstN) slvReqR <= '0;
    else for (int i = 0; i < NSLV; i++) begin
      if (slvReqR[i] && slvGnt[i]) begin
        if (holdLen[i] <= 1) begin
          slvReqR[i] <= 1'b0;
          holdLen[i] <= 0;
        end else holdLen[i] <= holdLen[i] - 1;
      end else if (!slvReqR[i] && holdLen[i] > 0 && isMaster) begin
        slvReqR[i] <= 1'b1;
      end
    end
  end

  // emulated controller (peripheral phase): grant follows request by one cycle
  logic grantInR = 1'b0;
  assign grantIn = grantInR;
  always @(posedge clk) begin
    if (!rstN) grantInR <= 1'b0;
    else grantInR <= reqOut && !isMaster;
  end

  // behavioural reference model
  int mMode = 0, mOwner = 0, mLast = NSLV - 1, sMode = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mOwner = 0; mLast = NSLV - 1; sMode = 0;
    end else if (isMaster) begin
      case (mMode)
        0: begin
          bit found;
          int pick;
          found = 0; pick = 0;
          for (int k = 1; k <= NSLV; k++) begin
            int c;
            c = (mLast + k) % NSLV;
            if (!found && slvReq[c]) begin found = 1; pick = c; end
          end
          if (found) begin mMode = 2; mOwner = pick; mLast = pick; end
          else if (txValid) mMode = 1;
        end
        1: if (!txValid) mMode = 0;
        2: if (!slvReq[mOwner]) mMode = 3;
        default: mMode = 0;
      endcase
    end else begin
      case (sMode)
        0: if (txValid) sMode = 1;
        1: if (grantIn) sMode = 2;
        default: if (!txValid) sMode = 0;
      endcase
    end
  end

  int gntOrder [$];
  logic [NSLV-1:0] prevGnt = '0;

  always @(negedge clk) begin
    logic expBusy, expOe, expReq;
    logic [NSLV-1:0] expGnt;
    logic [DW-1:0] expDout;
    expBusy = isMaster && (mMode != 0);
    expGnt  = (isMaster && mMode == 2) ? NSLV'(1 << mOwner) : '0;
    expOe   = txValid && ((isMaster && mMode == 1) ||
                          (!isMaster && sMode == 2 && grantIn));
    expReq  = !isMaster && (sMode != 0);
    expDout = expOe ? txData : '0;
    chk("R4 busyOut", busyOut, expBusy);
    chk("R5 slvGnt", slvGnt, expGnt);
    chk("R3 reqOut", reqOut, expReq);
    chk("R6 busOe", busOe, expOe);
    chk("R9 busDout", busDout, expDout);
    chk("R9 txPop", txPop, busOe);
    chk("R7 single driver", busOe && (slvGnt != '0), 1'b0);
    if (!isMaster) chk("R8 no grant/busy as peripheral", {slvGnt, busyOut}, '0);
    else chk("R8 no request as controller", reqOut, 1'b0);
    if (slvGnt != '0 && prevGnt == '0)
      for (int i = 0; i < NSLV; i++) if (slvGnt[i]) gntOrder.push_back(i);
    prevGnt = slvGnt;
  end

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    isMaster = 1'b1;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset outputs", {slvGnt, busyOut, reqOut, busOe, txPop, busDout}, '0);
    @(posedge clk); #1 rstN = 1'b1;
    waitCycles(2);

    // R2: single request, grant one cycle after the controller sees it
    holdLen[1] = 4;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R2 grant slave 1", slvGnt, 3'b010);
    chk("R2 busy with grant", busyOut, 1'b1);
    waitCycles(12);

    // R5: all three request together after slave 1 was last served
    gntOrder.delete();
    for (int i = 0; i < NSLV; i++) holdLen[i] = 2;
    waitCycles(30);
    chk("R5 grant count", gntOrder.size(), 3);
    if (gntOrder.size() == 3) begin
      chk("R5 first grant", gntOrder[0], 2);
      chk("R5 second grant", gntOrder[1], 0);
      chk("R5 third grant", gntOrder[2], 1);
    end

    // R6/R9: controller sends its own packets when idle
    srcCount = 3;
    waitCycles(8);
    chk("R9 all own packets popped", srcCount, 0);

    // R6: request arriving while the controller sends waits for the end
    gntOrder.delete();
    srcCount = 6;
    waitCycles(2);
    holdLen[0] = 2;
    waitCycles(3);
    chk("R6 no grant while sending", slvGnt, '0);
    waitCycles(20);
    chk("R6 waiting request served", gntOrder.size(), 1);
    if (gntOrder.size() == 1) chk("R6 served slave 0", gntOrder[0], 0);

    // mixed traffic
    for (int it = 0; it < 60; it++) begin
      int s;
      s = $urandom_range(0, NSLV - 1);
      if (holdLen[s] == 0 && $urandom_range(0, 1) == 1) holdLen[s] = $urandom_range(1, 4);
      if (srcCount == 0 && $urandom_range(0, 3) == 0) srcCount = $urandom_range(1, 3);
      waitCycles($urandom_range(1, 5));
    end
    waitCycles(40);

    // peripheral role
    rstN = 1'b0;
    isMaster = 1'b0;
    waitCycles(2);
    rstN = 1'b1;
    waitCycles(1);
    noiseReq = 3'b111;
    srcCount = 4;
    waitCycles(15);
    chk("R3 peripheral sent all packets", srcCount, 0);
    noiseReq = 3'b010;
    srcCount = 1;
    waitCycles(10);
    chk("R3 single packet sent", srcCount, 0);
    noiseReq = '0;
    srcCount = 2;
    waitCycles(10);
    chk("R8 peripheral idle", {slvGnt, busyOut}, '0);
    finishRun();
  end
endmodule